// File: doc/BRIEF.md
# Three-phase center-aligned PWM generator

This block drives three half-bridge phases. Each phase has a high-side output and a low-side output. All three phases run from one 16-bit timebase that counts up from zero to a programmed half-period and then back down. Each phase has its own duty value. That value places the phase's high-side on-window symmetrically about the middle of the switching period. The low-side output is the complement of the high side, except that each turn-on is held back by a programmable dead time.

Software writes the period, dead time, sync width, update mode and the three duty values over a simple synchronous write port. Each write lands in a shadow copy. The working copy is refreshed only at an update point. In single-update mode the only update point is the start of a period. In double-update mode the midpoint is also an update point, so the rising and falling halves of a period can use different settings. This gives asymmetric pulses.

The block emits a sync pulse of programmable width at each update point. It also gives a one-cycle interrupt at the start of each sync pulse and a flag that tells which half of the period is running. A shutdown input from an external protection controller forces all six outputs off at once and holds the timebase at rest.

The timebase is a three-state machine:
- IDLE: rest state during reset or shutdown.
- UP: rising half.
- DOWN: falling half.

Its transitions are:
- IDLE to UP (start): when shutdown is released.
- UP to DOWN (midpoint): when the count reaches the half-period minus one.
- DOWN to UP (period wrap): when the count reaches one.
- Any state to IDLE (shutdown): whenever shutdown is high.

Top module: `pwm3_gen`

## Requirements
- R1: While reset is active or shutdown is high, all six phase outputs are low, and after one clock edge the timebase rests in IDLE with half and sync low. The combinational gating turns the outputs off within the same cycle that shutdown rises. The first clock edge with shutdown low starts a new period, and that period is counted as k = 0.
- R2: A period lasts 2·P clocks, where P is the period value. A period value of 0 is treated as 1. The half flag is 0 for the first P clocks (k < P) and 1 for the next P clocks.
- R3: Let e be the distance from the period edge: e = k in the first half and e = 2P−1−k in the second half. With dead time 0 and 0 < D < P, the high output of a phase is 1 when e ≥ P−D and the low output is 1 when e < P−D. The high pulse therefore lasts 2·D clocks and is centered on the midpoint.
- R4: The dead time is 2·T clocks, where T is the dead-time value. In the first half, high turns on only when e ≥ P−D+2T. In the second half, low turns on only when e+2T < P−D. High and low of a phase are never 1 together.
- R5: With a duty of 0, the high output is 0 and the low output is 1 for the whole period. Otherwise, if D+2T ≥ P, the high output is 1 and the low output is 0 for the whole half.
- R6: Writes use the address map period = 0, dead time = 1, sync width = 2, mode = 3 (bit 0: 1 = double update), duty of phases 0/1/2 = 4/5/6. A write changes no output before the next update point.
- R7: In single-update mode the working values load only at period start. A duty write during the first half leaves the second half of that period unchanged and takes effect from the next period.
- R8: In double-update mode the duty, period, dead time and sync width also load at the midpoint. A duty write during the first half therefore shapes the second half of the same period. The mode bit itself loads only at period start.
- R9: The sync output is 1 for W clocks starting at k = 0, where W is the sync width and a value of 0 is treated as 1. In double-update mode it is also 1 for W clocks starting at k = P.
- R10: The interrupt output is 1 for exactly the first clock of each sync pulse (k = 0, and k = P in double-update mode) and 0 otherwise.
- R11: A write to address 7 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timebase tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| shut_i | input | 1 | Shutdown from protection logic, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pwm_hi_o | output | 3 | High-side drive, one bit per phase |
| pwm_lo_o | output | 3 | Low-side drive, one bit per phase |
| sync_o | output | 1 | Sync pulse at update points |
| half_o | output | 1 | 0 in the rising half, 1 in the falling half |
| irq_o | output | 1 | One-cycle interrupt at each sync pulse start |

## Verification
The hardest situation to reach from the ports is a register write that lands between two update points: the shadow and working copies differ, and the output must keep following the old working value. The bench gets there by releasing shutdown with a known configuration and counting clocks from the restart. It then writes a new duty, or writes to the unused address, at a fixed cycle inside the rising half, and checks every later cycle against the duty expected for each half in each mode. The saturation and zero-duty edges come from a sweep over every duty from 0 to P+1, with dead-time values 0 to 2 and period values 0 to 5, in both modes.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } tb_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DEAD   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_SYNCW  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DUTY0  = 3'd4;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic                    ld_start,
    input  logic                    ld_mid,
    output logic [CW-1:0]           act_per,
    output logic [CW-1:0]           act_dt,
    output logic                    act_mode,
    output logic [NPH-1:0][CW-1:0]  act_duty,
    output logic [CW-1:0]           mid_per,
    output logic [CW-1:0]           shd_sw
);
    logic [CW-1:0]          shd_per;
    logic [CW-1:0]          shd_dt;
    logic                   shd_mode;
    logic [NPH-1:0][CW-1:0] shd_duty;
    logic                   ld_any;

    // shadow copies: written at any time, never seen by the outputs directly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_per  <= '0;
            shd_dt   <= '0;
            shd_sw   <= '0;
            shd_mode <= 1'b0;
            shd_duty <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PERIOD) shd_per  <= wr_data;
            if (wr_addr == ADR_DEAD)   shd_dt   <= wr_data;
            if (wr_addr == ADR_SYNCW)  shd_sw   <= wr_data;
            if (wr_addr == ADR_MODE)   shd_mode <= wr_data[0];
            for (int i = 0; i < NPH; i++) begin
                if (wr_addr == ADR_DUTY0 + ADDR_W'(i)) shd_duty[i] <= wr_data;
            end
        end
    end

    assign ld_any = ld_start | (ld_mid & act_mode);

    // working copies: refreshed only at update points
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_per  <= '0;
            act_dt   <= '0;
            act_mode <= 1'b0;
            act_duty <= '0;
        end else begin
            if (ld_any) begin
                act_per  <= shd_per;
                act_dt   <= shd_dt;
                act_duty <= shd_duty;
            end
            if (ld_start) act_mode <= shd_mode;
        end
    end

    // half-period that the falling half will use
    assign mid_per = act_mode ? shd_per : act_per;
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shut,
    input  logic [CW-1:0] act_per,
    input  logic [CW-1:0] mid_per,
    input  logic [CW-1:0] sync_w,
    input  logic          act_mode,
    output tb_state_e     state_q,
    output logic [CW-1:0] cnt_q,
    output logic          ld_start,
    output logic          ld_mid,
    output logic          sync_o,
    output logic          irq_o,
    output logic          half_o
);
    tb_state_e     state_d;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] per_eff;
    logic [CW-1:0] mid_eff;
    logic [CW-1:0] sw_eff;
    logic [CW-1:0] sync_cnt;
    logic          sync_ev;

    assign per_eff = (act_per == '0) ? CW'(1) : act_per;
    assign mid_eff = (mid_per == '0) ? CW'(1) : mid_per;
    assign sw_eff  = (sync_w  == '0) ? CW'(1) : sync_w;

    // next-state and counter decisions
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        ld_start = 1'b0;
        ld_mid   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!shut) begin
                    state_d  = ST_UP;
                    ld_start = 1'b1;
                end
            end
            ST_UP: begin
                if (shut) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == per_eff - CW'(1)) begin
                    state_d = ST_DOWN;
                    cnt_d   = mid_eff;
                    ld_mid  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_DOWN: begin
                if (shut) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(1)) begin
                    state_d  = ST_UP;
                    cnt_d    = '0;
                    ld_start = 1'b1;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign sync_ev = ld_start | (ld_mid & act_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt <= '0;
            irq_o    <= 1'b0;
        end else begin
            irq_o <= sync_ev;
            if (shut)                  sync_cnt <= '0;
            else if (sync_ev)          sync_cnt <= sw_eff;
            else if (sync_cnt != '0)   sync_cnt <= sync_cnt - CW'(1);
        end
    end

    // outputs
    always_comb begin
        half_o = (state_q == ST_DOWN);
        sync_o = (sync_cnt != '0);
    end

    AST_SHUT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shut) |-> state_q == ST_IDLE) else $error("shutdown left timebase running"); // R1
    AST_UP_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_UP |-> cnt_q < per_eff) else $error("rising count out of range"); // R2
    AST_DOWN_ABOVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DOWN |-> cnt_q != '0) else $error("falling count reached zero"); // R2
    AST_IRQ_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> sync_o) else $error("interrupt outside sync pulse"); // R10
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          up,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per_eff,
    input  logic [CW-1:0] duty,
    input  logic [CW:0]   dtk,
    output logic          hi,
    output logic          lo
);
    localparam int XW = CW + 2;

    logic [XW-1:0] e_x, per_x, duty_x, dtk_x, raw_x;
    logic          full, zero, hi_raw, lo_raw;

    always_comb begin
        per_x  = XW'(per_eff);
        duty_x = XW'(duty);
        dtk_x  = XW'(dtk);
        e_x    = up ? XW'(cnt) : XW'(cnt) - XW'(1);
        raw_x  = per_x - duty_x;
        full   = (duty_x + dtk_x) >= per_x;
        zero   = (duty == '0);
        if (up) begin
            hi_raw = e_x >= raw_x + dtk_x;
            lo_raw = e_x < raw_x;
        end else begin
            hi_raw = e_x >= raw_x;
            lo_raw = (e_x + dtk_x) < raw_x;
        end
        hi = run & !zero & (full | hi_raw);
        lo = run & (zero | (!full & lo_raw));
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo)) else $error("both switches of a phase on"); // R4
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shut_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    output logic [NPH-1:0]    pwm_hi_o,
    output logic [NPH-1:0]    pwm_lo_o,
    output logic              sync_o,
    output logic              half_o,
    output logic              irq_o
);
    logic [CW-1:0]          act_per, act_dt, mid_per, shd_sw, cnt, per_eff;
    logic [NPH-1:0][CW-1:0] act_duty;
    logic                   act_mode, ld_start, ld_mid, run;
    tb_state_e              state;
    logic [CW:0]            dtk;

    pwm3_regs #(.CW(CW), .NPH(NPH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .ld_start(ld_start), .ld_mid(ld_mid),
        .act_per(act_per), .act_dt(act_dt), .act_mode(act_mode),
        .act_duty(act_duty), .mid_per(mid_per), .shd_sw(shd_sw)
    );

    pwm3_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .shut(shut_i),
        .act_per(act_per), .mid_per(mid_per), .sync_w(shd_sw),
        .act_mode(act_mode),
        .state_q(state), .cnt_q(cnt),
        .ld_start(ld_start), .ld_mid(ld_mid),
        .sync_o(sync_o), .irq_o(irq_o), .half_o(half_o)
    );

    assign per_eff = (act_per == '0) ? CW'(1) : act_per;
    assign dtk     = {act_dt, 1'b0};
    assign run     = !shut_i && (state != ST_IDLE);

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        pwm3_phase #(.CW(CW)) u_phase (
            .clk(clk), .rst_n(rst_n),
            .run(run), .up(state == ST_UP), .cnt(cnt),
            .per_eff(per_eff), .duty(act_duty[g]), .dtk(dtk),
            .hi(pwm_hi_o[g]), .lo(pwm_lo_o[g])
        );
    end
endmodule

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shut = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  hi, lo;
    logic        sync, half, irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pwm3_gen u_pwm3_gen (
        .clk(clk), .rst_n(rst_n), .shut_i(shut),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pwm_hi_o(hi), .pwm_lo_o(lo),
        .sync_o(sync), .half_o(half), .irq_o(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {hi,lo} from the requirement formulas
    function automatic logic [1:0] exp_pair(input int e, input bit up_half,
                                            input int p, input int d, input int t);
        int dt2 = 2 * t;
        int raw = p - d;
        if (d == 0)        return 2'b01;
        if (d + dt2 >= p)  return 2'b10;
        if (up_half)       return {e >= raw + dt2, e < raw};
        return {e >= raw, e + dt2 < raw};
    endfunction

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic string pair_tag(input int p, input int d, input int t);
        if (d == 0 || d + 2 * t >= p) return "R5";
        if (t > 0) return "R4";
        return "R3";
    endfunction

    task automatic run_cfg(input int p, input int m, input int t, input int d, input int w);
        int pe = (p == 0) ? 1 : p;
        int we = (w == 0) ? 1 : w;
        int dd[3];
        dd[0] = d; dd[1] = (d + 1) % (pe + 2); dd[2] = (d + pe) % (pe + 2);
        wr(3'd0, p); wr(3'd1, t); wr(3'd2, w); wr(3'd3, m);
        wr(3'd4, dd[0]); wr(3'd5, dd[1]); wr(3'd6, dd[2]);
        shut = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 4 * pe; k++) begin
            int kk = k % (2 * pe);
            bit uph = kk < pe;
            int e = uph ? kk : 2 * pe - 1 - kk;
            bit es, ei;
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                logic [1:0] ex = exp_pair(e, uph, pe, dd[i], t);
                chk(pair_tag(pe, dd[i], t), int'({hi[i], lo[i]}), int'(ex));
            end
            chk("R2 half", int'(half), int'(!uph));
            es = (kk < we) || (m == 1 && kk >= pe && kk < pe + we);
            ei = (kk == 0) || (m == 1 && kk == pe);
            chk(m ? "R9 double sync" : "R9 sync", int'(sync), int'(es));
            chk("R10 irq", int'(irq), int'(ei));
        end
        shut = 1'b1;
    endtask

    // write at k=1 during the rising half; check phase 0 per half
    task automatic mid_write(input int m, input logic [2:0] a, input int nv, input bit takes);
        int pe = 6;
        wr(3'd0, pe); wr(3'd1, 0); wr(3'd2, 1); wr(3'd3, m);
        wr(3'd4, 2); wr(3'd5, 2); wr(3'd6, 2);
        shut = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 4 * pe; k++) begin
            int kk = k % (2 * pe);
            bit uph = kk < pe;
            int e = uph ? kk : 2 * pe - 1 - kk;
            int dnow;
            logic [1:0] ex;
            @(negedge clk);
            if (!takes)            dnow = 2;
            else if (k < pe)       dnow = 2;
            else if (k < 2 * pe)   dnow = (m == 1) ? nv : 2;
            else                   dnow = nv;
            ex = exp_pair(e, uph, pe, dnow, 0);
            if (!takes)       chk("R11 addr7", int'({hi[0], lo[0]}), int'(ex));
            else if (k < pe)  chk("R6 shadow", int'({hi[0], lo[0]}), int'(ex));
            else if (m == 1)  chk("R8 double", int'({hi[0], lo[0]}), int'(ex));
            else              chk("R7 single", int'({hi[0], lo[0]}), int'(ex));
            if (!takes) chk("R11 sync", int'(sync), int'(kk == 0 || (m == 1 && kk == pe)));
            if (k == 1) begin
                wr_en = 1'b1; wr_addr = a; wr_data = 16'(nv);
            end else begin
                wr_en = 1'b0;
            end
        end
        shut = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset hi", int'(hi), 0);
        chk("R1 reset lo", int'(lo), 0);
        chk("R1 reset half", int'(half), 0);
        chk("R1 reset sync", int'(sync), 0);
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 shut hi", int'(hi), 0);
        chk("R1 shut lo", int'(lo), 0);

        for (int p = 0; p <= 5; p++)
            for (int m = 0; m <= 1; m++)
                for (int t = 0; t <= 2; t++) begin
                    int pe = (p == 0) ? 1 : p;
                    for (int d = 0; d <= pe + 1; d++)
                        run_cfg(p, m, t, d, 1 + (d % pe));
                end

        mid_write(0, 3'd4, 4, 1'b1);
        mid_write(1, 3'd4, 4, 1'b1);
        mid_write(0, 3'd7, 16'hFFFF, 1'b0);
        mid_write(1, 3'd7, 0, 1'b0);

        // shutdown in the middle of a falling half
        wr(3'd0, 4); wr(3'd1, 0); wr(3'd2, 2); wr(3'd3, 0);
        wr(3'd4, 3); wr(3'd5, 3); wr(3'd6, 3);
        shut = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 6; k++) @(negedge clk);
        chk("R1 pre-shut hi", int'(hi), 7);
        shut = 1'b1;
        #1;
        chk("R1 shut same cycle hi", int'(hi), 0);
        chk("R1 shut same cycle lo", int'(lo), 0);
        @(negedge clk);
        chk("R1 shut half", int'(half), 0);
        chk("R1 shut sync", int'(sync), 0);
        shut = 1'b0;
        @(negedge clk);
        chk("R1 restart half", int'(half), 0);
        chk("R1 restart sync", int'(sync), 1);
        chk("R1 restart irq", int'(irq), 1);
        chk("R1 restart lo", int'(lo), 7);
        shut = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule